// File: doc/BRIEF.md
# Byte-Wide Flash Command Controller

This block accepts command writes on a simple synchronous bus and controls a small byte-wide flash array held in registers. A command write selects what reads return: array bytes, two identifier bytes, or a status byte. The block also runs two-cycle sector erase and two-cycle byte program operations. Each operation first checks the target sector's write-lock input and the write-protect pin for that sector's group. The time a real cell would need is replaced by a busy counter. Its length is a parameter, so software polls the ready bit exactly as it would with real silicon.

The array is divided into sectors of unequal size. Each sector is a multiple of `UNIT` bytes. `N_MAIN` main sectors of 8 units each come first, followed by four boot/parameter sectors of 4, 1, 1 and 2 units. This keeps the 64:32:8:8:16 size ratio. There is no command that erases the whole array. Programming can only clear bits. A check after the program flags any bit that was asked to be 1 but stays 0.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, reads return array data (mode array), every array byte reads 0xFF, and the status byte reads 0x80. The read data register updates on the clock edge that samples `rd_en`.
- R2: Writing 0x90 selects identifier mode. In this mode a read at address 0 returns 0x1F, a read at address 1 returns 0xEA, and any other address returns 0x00. Any valid command leaves this mode.
- R3: The status byte is {ready, 0, erase error, program error, 0, 0, lock error, 0}, with ready as bit 7 and equal to 1 when no operation runs. Writing 0x70, 0x20 or 0x40 makes reads return the status byte. Reads stay on status after an erase or program until another command is accepted.
- R4: A write of 0x20 followed by a write of 0xD0 erases the sector that contains the address of the 0xD0 write. At the end of the operation every byte of that sector is 0xFF, and bytes outside it are unchanged.
- R5: With the defaults (`N_MAIN`=3, `UNIT`=4), the sectors span bytes 0-31, 32-63, 64-95, 96-111, 112-115, 116-119 and 120-127. Sectors 0-2 are main sectors and sectors 3-6 are boot sectors.
- R6: A write of 0x40 followed by a data write stores the old byte ANDed with the data at the address of the data write. Both address and data are taken from the second write.
- R7: A program whose data holds a 1 where the old byte holds a 0 sets status bit 4. The stored value is still the AND of the two.
- R8: An erase or program is rejected if `sec_lock[s]` is set for the target sector s, or if the group pin is high (`wp_main` for sectors below `N_MAIN`, `wp_boot` otherwise). A rejected operation leaves the array unchanged, sets status bit 1 together with bit 5 (erase) or bit 4 (program), and does not make the block busy.
- R9: Ready is 0 for `PROG_CYC` cycles after a program starts and for `ERASE_CYC` cycles after an erase starts. Every write sampled while ready is 0 is ignored, including 0xFF. This also covers a write sampled on the final busy cycle.
- R10: A second erase cycle whose data is not 0xD0 sets status bits 5 and 4, erases nothing, and returns reads to array mode.
- R11: Error bits stay set until 0x50 is written. Writing 0x50 clears bits 5, 4 and 1 and selects array mode.
- R12: A write of any other opcode while no two-cycle command is pending is ignored, and the read mode is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command/data write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data (opcode or program data) |
| rd_data | output | 8 | Registered read data |
| sec_lock | input | N_MAIN+4 | Per-sector write-lock bits |
| wp_main | input | 1 | Write-protect for main sectors, active high |
| wp_boot | input | 1 | Write-protect for boot sectors, active high |

## Verification
Two events can fall on the same clock edge: an operation finishing, and a bus write or read being sampled. On that last busy edge a read still reports ready as 0, and a write (even 0xFF) is still discarded. The bench provokes this by placing a read and a read-array write exactly `ERASE_CYC` edges after an erase confirm. A behavioural model, updated on every edge, predicts the busy status byte and the status mode that persists afterwards. Each registered read is compared against that model, together with literal expected values for the key bytes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int NBOOT = 4;

  typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_STATUS} rmode_e;
  typedef enum logic [1:0] {PH_IDLE, PH_ERASE_ARM, PH_PROG_ARM} phase_e;

  localparam logic [7:0] OP_READ    = 8'hFF;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_PROG    = 8'h40;
  localparam logic [7:0] OP_CLEAR   = 8'h50;
  localparam logic [7:0] OP_STATUS  = 8'h70;

  localparam logic [7:0] MFR_CODE = 8'h1F;
  localparam logic [7:0] DEV_CODE = 8'hEA;

  // size of sector idx in units; boot group keeps the 4:1:1:2 pattern
  function automatic int sec_units(int idx, int n_main);
    if (idx < n_main) return 8;
    case (idx - n_main)
      0:       return 4;
      1:       return 1;
      2:       return 1;
      default: return 2;
    endcase
  endfunction

  function automatic int total_units(int n_main);
    return 8 * n_main + 8;
  endfunction

  function automatic int max_int(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // sector index holding byte address a
  function automatic int sec_of(int a, int n_main, int unit);
    int base;
    int res;
    bit found;
    base  = 0;
    res   = 0;
    found = 1'b0;
    for (int i = 0; i < n_main + NBOOT; i++) begin
      if (!found && a < base + sec_units(i, n_main) * unit) begin
        res   = i;
        found = 1'b1;
      end
      base = base + sec_units(i, n_main) * unit;
    end
    return res;
  endfunction

  function automatic logic [7:0] prog_merge(logic [7:0] old_b, logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  // a requested 1 over a stored 0 cannot be reached by programming
  function automatic logic prog_fault(logic [7:0] old_b, logic [7:0] new_b);
    return |(new_b & ~old_b);
  endfunction

endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] load_val,
  output logic          busy,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  assign done = busy && (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (start) begin
      cnt_q <= load_val;
      busy  <= 1'b1;
    end else if (busy) begin
      cnt_q <= cnt_q - CW'(1);
      if (done) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_array.sv
module flash_array import flash_cmd_pkg::*; #(
  parameter  int N_MAIN = 3,
  parameter  int UNIT   = 4,
  localparam int DEPTH  = UNIT * total_units(N_MAIN),
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          apply_erase,
  input  logic          apply_prog,
  input  logic [AW-1:0] op_addr,
  input  logic [7:0]    op_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_byte,
  output logic          prog_miss
);

  logic [7:0] cells [DEPTH];
  int         tgt_sec;

  always_comb tgt_sec = sec_of(int'(op_addr), N_MAIN, UNIT);

  // each byte knows its sector at elaboration, so an erase is one cycle
  for (genvar j = 0; j < DEPTH; j++) begin : g_byte
    localparam int MY_SEC = sec_of(j, N_MAIN, UNIT);
    logic [7:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= 8'hFF;
      end else if (apply_erase && tgt_sec == MY_SEC) begin
        cell_q <= 8'hFF;
      end else if (apply_prog && op_addr == AW'(j)) begin
        cell_q <= prog_merge(cell_q, op_data);
      end
    end
    assign cells[j] = cell_q;
  end

  assign rd_byte   = cells[rd_addr];
  assign prog_miss = prog_fault(cells[op_addr], op_data);

endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode import flash_cmd_pkg::*; #(
  parameter  int N_MAIN    = 3,
  parameter  int UNIT      = 4,
  parameter  int PROG_CYC  = 4,
  parameter  int ERASE_CYC = 12,
  localparam int NSEC      = N_MAIN + NBOOT,
  localparam int SW        = $clog2(NSEC),
  localparam int DEPTH     = UNIT * total_units(N_MAIN),
  localparam int AW        = $clog2(DEPTH),
  localparam int CW        = $clog2(max_int(PROG_CYC, ERASE_CYC) + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [7:0]      wdata,
  input  logic [NSEC-1:0] sec_lock,
  input  logic            wp_main,
  input  logic            wp_boot,
  input  logic            busy,
  input  logic            done,
  input  logic            prog_miss,
  output rmode_e          mode_q,
  output logic            op_start,
  output logic [CW-1:0]   load_val,
  output logic            op_erase_q,
  output logic [AW-1:0]   op_addr_q,
  output logic [7:0]      op_data_q,
  output logic            err_erase_q,
  output logic            err_prog_q,
  output logic            err_lock_q,
  output logic            ev_lock_reject,
  output logic            ev_clear
);

  phase_e        phase_q;
  logic          wr_ok;
  logic [SW-1:0] wsec;
  logic          target_locked;
  logic          arm_hit;
  logic          ev_bad_confirm;

  always_comb begin
    wr_ok          = wr_en && !busy;
    wsec           = SW'(sec_of(int'(addr), N_MAIN, UNIT));
    target_locked  = sec_lock[wsec] || ((int'(wsec) < N_MAIN) ? wp_main : wp_boot);
    arm_hit        = wr_ok && ((phase_q == PH_ERASE_ARM && wdata == OP_CONFIRM) ||
                               phase_q == PH_PROG_ARM);
    op_start       = arm_hit && !target_locked;
    ev_lock_reject = arm_hit && target_locked;
    ev_bad_confirm = wr_ok && phase_q == PH_ERASE_ARM && wdata != OP_CONFIRM;
    ev_clear       = wr_ok && phase_q == PH_IDLE && wdata == OP_CLEAR;
    load_val       = (phase_q == PH_ERASE_ARM) ? CW'(ERASE_CYC) : CW'(PROG_CYC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= RM_ARRAY;
      phase_q     <= PH_IDLE;
      op_erase_q  <= 1'b0;
      op_addr_q   <= '0;
      op_data_q   <= 8'hFF;
      err_erase_q <= 1'b0;
      err_prog_q  <= 1'b0;
      err_lock_q  <= 1'b0;
    end else begin
      if (done && !op_erase_q && prog_miss) err_prog_q <= 1'b1;
      if (wr_ok) begin
        case (phase_q)
          PH_ERASE_ARM: begin
            phase_q <= PH_IDLE;
            if (ev_bad_confirm) begin
              err_erase_q <= 1'b1;
              err_prog_q  <= 1'b1;
              mode_q      <= RM_ARRAY;
            end else begin
              op_erase_q <= 1'b1;
              op_addr_q  <= addr;
              if (target_locked) begin
                err_erase_q <= 1'b1;
                err_lock_q  <= 1'b1;
              end
            end
          end
          PH_PROG_ARM: begin
            phase_q    <= PH_IDLE;
            op_erase_q <= 1'b0;
            op_addr_q  <= addr;
            op_data_q  <= wdata;
            if (target_locked) begin
              err_prog_q <= 1'b1;
              err_lock_q <= 1'b1;
            end
          end
          default: begin
            case (wdata)
              OP_READ:   mode_q <= RM_ARRAY;
              OP_IDENT:  mode_q <= RM_IDENT;
              OP_STATUS: mode_q <= RM_STATUS;
              OP_ERASE: begin
                phase_q <= PH_ERASE_ARM;
                mode_q  <= RM_STATUS;
              end
              OP_PROG: begin
                phase_q <= PH_PROG_ARM;
                mode_q  <= RM_STATUS;
              end
              OP_CLEAR: begin
                err_erase_q <= 1'b0;
                err_prog_q  <= 1'b0;
                err_lock_q  <= 1'b0;
                mode_q      <= RM_ARRAY;
              end
              default: ;
            endcase
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl import flash_cmd_pkg::*; #(
  parameter  int N_MAIN    = 3,
  parameter  int UNIT      = 4,
  parameter  int PROG_CYC  = 4,
  parameter  int ERASE_CYC = 12,
  localparam int NSEC      = N_MAIN + NBOOT,
  localparam int DEPTH     = UNIT * total_units(N_MAIN),
  localparam int ADDR_W    = $clog2(DEPTH),
  localparam int CW        = $clog2(max_int(PROG_CYC, ERASE_CYC) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rd_data,
  input  logic [NSEC-1:0]   sec_lock,
  input  logic              wp_main,
  input  logic              wp_boot
);

  rmode_e            mode_q;
  logic              busy;
  logic              op_done;
  logic              op_start;
  logic [CW-1:0]     load_val;
  logic              op_erase_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [7:0]        op_data_q;
  logic              err_erase;
  logic              err_prog;
  logic              err_lock;
  logic              ev_lock_reject;
  logic              ev_clear;
  logic              prog_miss;
  logic [7:0]        arr_byte;
  logic [7:0]        id_byte;
  logic [7:0]        status_byte;

  flash_cmd_decode #(
    .N_MAIN(N_MAIN), .UNIT(UNIT), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .sec_lock(sec_lock), .wp_main(wp_main), .wp_boot(wp_boot),
    .busy(busy), .done(op_done), .prog_miss(prog_miss),
    .mode_q(mode_q), .op_start(op_start), .load_val(load_val),
    .op_erase_q(op_erase_q), .op_addr_q(op_addr_q), .op_data_q(op_data_q),
    .err_erase_q(err_erase), .err_prog_q(err_prog), .err_lock_q(err_lock),
    .ev_lock_reject(ev_lock_reject), .ev_clear(ev_clear)
  );

  flash_busy_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(op_start), .load_val(load_val),
    .busy(busy), .done(op_done)
  );

  flash_array #(.N_MAIN(N_MAIN), .UNIT(UNIT)) u_array (
    .clk(clk), .rst_n(rst_n),
    .apply_erase(op_done && op_erase_q), .apply_prog(op_done && !op_erase_q),
    .op_addr(op_addr_q), .op_data(op_data_q),
    .rd_addr(addr), .rd_byte(arr_byte), .prog_miss(prog_miss)
  );

  always_comb begin
    status_byte = {~busy, 1'b0, err_erase, err_prog, 2'b00, err_lock, 1'b0};
    if (addr == ADDR_W'(0))      id_byte = MFR_CODE;
    else if (addr == ADDR_W'(1)) id_byte = DEV_CODE;
    else                         id_byte = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= 8'h00;
    end else if (rd_en) begin
      case (mode_q)
        RM_ARRAY: rd_data <= arr_byte;
        RM_IDENT: rd_data <= id_byte;
        default:  rd_data <= status_byte;
      endcase
    end
  end

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk import flash_cmd_pkg::*; #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rd_data,
  input logic [1:0]        mode,
  input logic              busy,
  input logic              op_start,
  input logic              ev_lock_reject,
  input logic              ev_clear,
  input logic [7:0]        status
);

  // R9: no command may change the read mode while an operation runs
  p_mode_frozen_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode));

  // R9: the decoder never launches a second operation over a running one
  p_no_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> !busy);

  // R3: a launched operation drops ready and leaves reads on status
  p_start_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> (!status[7] && mode == 2'(RM_STATUS)));

  // R8: a rejected operation records the lock error and stays ready
  p_lock_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock_reject |=> (status[1] && status[7]));

  // R11: the program error bit persists without a clear command
  p_sticky_prog_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !ev_clear) |=> status[4]);

  // R11: clear command empties all error bits
  p_clear_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clear |=> (status[5:4] == 2'b00 && !status[1]));

  // R2: identifier mode returns the manufacturer code at address 0
  p_ident_mfr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == 2'(RM_IDENT) && addr == '0) |=> rd_data == MFR_CODE);

  wire unused_ok = wr_en;

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rd_data(rd_data), .mode(mode_q), .busy(busy), .op_start(op_start),
  .ev_lock_reject(ev_lock_reject), .ev_clear(ev_clear), .status(status_byte)
);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;

  localparam int DEPTH = 128;
  localparam int PCYC  = 4;
  localparam int ECYC  = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rd_data;
  logic [6:0] sec_lock = '0;
  logic       wp_main = 1'b0;
  logic       wp_boot = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .sec_lock(sec_lock),
    .wp_main(wp_main), .wp_boot(wp_boot)
  );

  int    checks = 0;
  int    fails = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  // behavioural reference model
  int m_mem [DEPTH];
  int m_mode;      // 0 array, 1 ident, 2 status
  int m_phase;     // 0 idle, 1 erase armed, 2 program armed
  bit m_ee, m_pe, m_le;
  int m_cnt;
  bit m_oerase;
  int m_oaddr, m_odata;
  int exp_rd;
  bit exp_valid = 1'b0;

  function automatic int tb_sec(int a);
    if (a < 32)  return 0;
    if (a < 64)  return 1;
    if (a < 96)  return 2;
    if (a < 112) return 3;
    if (a < 116) return 4;
    if (a < 120) return 5;
    return 6;
  endfunction

  function automatic bit tb_locked(int a);
    return sec_lock[tb_sec(a)] || (tb_sec(a) < 3 ? wp_main : wp_boot);
  endfunction

  function automatic int tb_read(int a);
    if (m_mode == 0) return m_mem[a];
    if (m_mode == 1) return (a == 0) ? 'h1F : (a == 1) ? 'hEA : 0;
    return (m_cnt > 0 ? 0 : 128) + (m_ee ? 32 : 0) + (m_pe ? 16 : 0) + (m_le ? 2 : 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 255;
      m_mode = 0; m_phase = 0; m_ee = 0; m_pe = 0; m_le = 0; m_cnt = 0;
      m_oerase = 0; m_oaddr = 0; m_odata = 255;
      exp_valid = 0;
    end else begin
      bit was_busy;
      int a, d;
      a = int'(addr);
      d = int'(wdata);
      exp_valid = rd_en;
      if (rd_en) exp_rd = tb_read(a);
      was_busy = (m_cnt > 0);
      if (m_cnt == 1) begin
        if (m_oerase) begin
          for (int i = 0; i < DEPTH; i++)
            if (tb_sec(i) == tb_sec(m_oaddr)) m_mem[i] = 255;
        end else begin
          if ((m_odata & ~m_mem[m_oaddr] & 255) != 0) m_pe = 1;
          m_mem[m_oaddr] = m_mem[m_oaddr] & m_odata;
        end
      end
      if (m_cnt > 0) m_cnt--;
      if (wr_en && !was_busy) begin
        if (m_phase == 1) begin
          m_phase = 0;
          if (d != 'hD0) begin
            m_ee = 1; m_pe = 1; m_mode = 0;
          end else if (tb_locked(a)) begin
            m_ee = 1; m_le = 1;
          end else begin
            m_oerase = 1; m_oaddr = a; m_cnt = ECYC;
          end
        end else if (m_phase == 2) begin
          m_phase = 0;
          if (tb_locked(a)) begin
            m_pe = 1; m_le = 1;
          end else begin
            m_oerase = 0; m_oaddr = a; m_odata = d; m_cnt = PCYC;
          end
        end else begin
          case (d)
            'hFF: m_mode = 0;
            'h90: m_mode = 1;
            'h70: m_mode = 2;
            'h20: begin m_phase = 1; m_mode = 2; end
            'h40: begin m_phase = 2; m_mode = 2; end
            'h50: begin m_ee = 0; m_pe = 0; m_le = 0; m_mode = 0; end
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(bit ok, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", cur_req, act, expv);
    end
  endtask

  // compare every registered read against the model
  always @(negedge clk) begin
    if (rst_n && exp_valid && !finished) chk(rd_data == 8'(exp_rd), rd_data, exp_rd);
  end

  task automatic drive(bit w, bit r, int a, int d);
    wr_en = w; rd_en = r; addr = 7'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(int a, int d); drive(1, 0, a, d); endtask
  task automatic rd(int a); drive(0, 1, a, 0); endtask
  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic rd_lit(int a, int e);
    rd(a);
    chk(rd_data == 8'(e), rd_data, e);
  endtask

  task automatic prog(int a, int d);
    wr(0, 'h40); wr(a, d); idle(PCYC + 1);
  endtask

  task automatic erase(int a);
    wr(0, 'h20); wr(a, 'hD0); idle(ECYC + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R1";
    rd_lit(0, 'hFF); rd_lit(127, 'hFF);
    wr(0, 'h70); rd_lit(0, 'h80); wr(0, 'hFF);

    cur_req = "R2";
    wr(0, 'h90); rd_lit(0, 'h1F); rd_lit(1, 'hEA); rd_lit(5, 'h00);
    wr(0, 'h70); rd_lit(0, 'h80); wr(0, 'hFF);

    cur_req = "R6";
    wr(0, 'h40); wr(10, 'hA5);
    cur_req = "R3";
    rd_lit(10, 'h00);            // busy status while programming
    idle(PCYC); wr(0, 'hFF);
    cur_req = "R6";
    rd_lit(10, 'hA5);
    cur_req = "R7";
    prog(10, 'h5A); rd_lit(0, 'h90);
    wr(0, 'hFF); rd_lit(10, 'h00);
    cur_req = "R11";
    wr(0, 'h50); wr(0, 'h70); rd_lit(0, 'h80); wr(0, 'hFF);

    cur_req = "R5";
    prog(95, 0); prog(96, 0); prog(111, 0); prog(112, 0); prog(120, 0);
    cur_req = "R4";
    erase(100); wr(0, 'hFF);
    cur_req = "R5";
    rd_lit(95, 'h00); rd_lit(96, 'hFF); rd_lit(111, 'hFF); rd_lit(112, 'h00);
    cur_req = "R4";
    erase(115); wr(0, 'hFF); rd_lit(112, 'hFF); rd_lit(120, 'h00);

    cur_req = "R8";
    sec_lock[0] = 1'b1;
    prog(5, 'h00); rd_lit(0, 'h92);
    wr(0, 'hFF); rd_lit(5, 'hFF);
    wr(0, 'h50); sec_lock[0] = 1'b0;
    wp_boot = 1'b1;
    erase(120); rd_lit(0, 'hA2);
    wr(0, 'hFF); rd_lit(120, 'h00);
    wr(0, 'h50); wp_boot = 1'b0;
    wp_main = 1'b1;
    prog(117, 'h0F); wr(0, 'hFF); rd_lit(117, 'h0F);
    wp_main = 1'b0;

    cur_req = "R9";
    prog(3, 'h00);
    wr(0, 'h20); wr(3, 'hD0);    // erase start edge E
    wr(0, 'hFF); wr(0, 'h90); wr(0, 'h40);
    rd_lit(0, 'h00);
    idle(ECYC - 5);
    drive(1, 1, 0, 'hFF);        // sampled on the final busy edge
    chk(rd_data == 8'h00, rd_data, 'h00);
    rd_lit(0, 'h80);             // still status mode
    wr(0, 'hFF); rd_lit(3, 'hFF);

    cur_req = "R10";
    prog(0, 'h0F);
    wr(0, 'h20); wr(0, 'h33);
    rd_lit(0, 'h0F);
    wr(0, 'h70); rd_lit(0, 'hB0);

    cur_req = "R11";
    wr(0, 'hFF); wr(0, 'h70); rd_lit(0, 'hB0);
    wr(0, 'h50); rd_lit(0, 'h0F);
    wr(0, 'h70); rd_lit(0, 'h80);

    cur_req = "R12";
    wr(0, 'h90); wr(0, 'h12); rd_lit(0, 'h1F);
    wr(0, 'h07); rd_lit(1, 'hEA);
    wr(0, 'hFF); rd_lit(0, 'h0F);

    idle(2);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule